// File: doc/BRIEF.md
# Packed Complex SIMD Multiplier

This block multiplies two packed vectors of 16-bit complex numbers, lane by lane. Each 64-bit operand holds two complex elements. Every 32-bit element carries its real part in the upper half-word and its imaginary part in the lower half-word, and lane 1 sits in the upper 32 bits. Both lanes are computed in the same issue, and each lane multiplies only with the lane of the same index in the other operand.

Two result formats are offered. The widening format returns both products at full 32-bit precision per component, packed into 128 bits. The rounded format treats the inputs as Q15 fractions and returns both products as 16-bit components packed into the low 64 bits. A per-issue select also conjugates the second operand before the multiply. A new operation can issue on every clock, and there is no handshake. Each result appears two clocks later with a valid flag.

Top module: `cpx_simd_mul`

## Requirements
- R1: Lane l of an operand is bits [32l+31:32l], with the real part in bits [32l+31:32l+16] and the imaginary part in bits [32l+15:32l]. Each lane's result depends only on the same lane of both operands.
- R2: With in_round=0 and in_conj=0, lane l of out_data is bits [64l+63:64l]. Its real part, in the upper 32 bits, is ar*br - ai*bi. Its imaginary part, in the lower 32 bits, is ar*bi + ai*br. Both are signed and wrap modulo 2^32.
- R3: With in_conj=1, the imaginary part of each second-operand element is negated before the multiply. The real part is then ar*br + ai*bi and the imaginary part is ai*br - ar*bi. This is computed exactly, so -32768 is negated correctly.
- R4: With in_round=1, each exact component sum has 2^14 added to it, is shifted right arithmetically by 15 and is saturated to [-32768, 32767]. Lane l is placed at out_data bits [32l+31:32l], with real in the upper 16 bits.
- R5: With in_round=1, out_data bits [127:64] are zero.
- R6: A result appears exactly two clocks after it is issued. out_valid is high in that cycle only when in_valid was high at issue.
- R7: While rst is high, and after it is released until the first result arrives, out_valid is 0 and out_data is 0.
- R8: Mode and conjugate selects are taken per issue, so back-to-back issues with different selects each produce their own format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe |
| in_a | input | 64 | First operand, two packed complex elements |
| in_b | input | 64 | Second operand, two packed complex elements |
| in_round | input | 1 | 1 selects the rounded 16-bit format, 0 selects the 32-bit format |
| in_conj | input | 1 | 1 conjugates in_b before the multiply |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Packed result |

## Verification
Directed vectors put a nonzero value in one lane and zero in the other, which shows that the lanes are routed apart and packed in the right order. Vectors built from -32768 and 32767 separate exact arithmetic from wrapped arithmetic. The square of -32768 summed twice reaches 2^31, which must wrap in the widening format and must saturate in the rounded format, and -32768 also shows whether the conjugate is taken exactly. Back-to-back issues that alternate the mode and conjugate selects, with gaps where in_valid is low, show whether the selects travel with their data. Random vectors biased toward extremes cover the remaining sign combinations and the rounding boundary.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    localparam int EW = 16;          // component width of an input element
    localparam int PW = 2 * EW;      // product / wide component width
    localparam int SW = PW + 1;      // exact width of a two-product sum

    typedef struct packed {
        logic signed [EW-1:0] re;
        logic signed [EW-1:0] im;
    } cpx_t;

    typedef struct packed {
        logic signed [PW-1:0] re;
        logic signed [PW-1:0] im;
    } wide_t;

    typedef struct packed {
        logic signed [PW-1:0] rr;    // ar*br
        logic signed [PW-1:0] ii;    // ai*bi
        logic signed [PW-1:0] ri;    // ar*bi
        logic signed [PW-1:0] ir;    // ai*br
    } prod_t;

    typedef enum logic {
        FMT_WIDE  = 1'b0,
        FMT_ROUND = 1'b1
    } fmt_e;

    localparam logic signed [SW:0] RND_MAX  = (SW+1)'((1 << (EW-1)) - 1);
    localparam logic signed [SW:0] RND_MIN  = ~RND_MAX;
    localparam logic signed [SW:0] RND_HALF = (SW+1)'(1 << (EW-2));

    // Q15 round-half-up and saturate of an exact sum
    function automatic logic signed [EW-1:0] round_sat(input logic signed [SW-1:0] v);
        logic signed [SW:0] t;
        logic signed [SW:0] sh;
        t  = $signed({v[SW-1], v}) + RND_HALF;
        sh = t >>> (EW-1);
        if (sh > RND_MAX)      round_sat = RND_MAX[EW-1:0];
        else if (sh < RND_MIN) round_sat = RND_MIN[EW-1:0];
        else                   round_sat = sh[EW-1:0];
    endfunction

endpackage

// File: rtl/cmul_prod.sv
module cmul_prod
    import cmul_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cpx_t  op_a,
    input  cpx_t  op_b,
    output prod_t prod_q
);

    prod_t prod_d;

    always_comb begin
        prod_d.rr = PW'($signed(op_a.re)) * PW'($signed(op_b.re));
        prod_d.ii = PW'($signed(op_a.im)) * PW'($signed(op_b.im));
        prod_d.ri = PW'($signed(op_a.re)) * PW'($signed(op_b.im));
        prod_d.ir = PW'($signed(op_a.im)) * PW'($signed(op_b.re));
    end

    always_ff @(posedge clk) begin
        if (rst) prod_q <= '0;
        else     prod_q <= prod_d;
    end

endmodule

// File: rtl/cmul_combine.sv
module cmul_combine
    import cmul_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  prod_t prod,
    input  logic  conj,
    output wide_t wide_q,
    output cpx_t  rnd_q
);

    logic signed [SW-1:0] rr_x, ii_x, ri_x, ir_x;
    logic signed [SW-1:0] re_sum, im_sum;

    always_comb begin
        rr_x = {prod.rr[PW-1], prod.rr};
        ii_x = {prod.ii[PW-1], prod.ii};
        ri_x = {prod.ri[PW-1], prod.ri};
        ir_x = {prod.ir[PW-1], prod.ir};
        if (conj) begin
            re_sum = rr_x + ii_x;
            im_sum = ir_x - ri_x;
        end else begin
            re_sum = rr_x - ii_x;
            im_sum = ri_x + ir_x;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wide_q <= '0;
            rnd_q  <= '0;
        end else begin
            wide_q.re <= re_sum[PW-1:0];
            wide_q.im <= im_sum[PW-1:0];
            rnd_q.re  <= round_sat(re_sum);
            rnd_q.im  <= round_sat(im_sum);
        end
    end

endmodule

// File: rtl/cpx_simd_mul.sv
module cpx_simd_mul
    import cmul_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [LANES*PW-1:0]     in_a,
    input  logic [LANES*PW-1:0]     in_b,
    input  logic                    in_round,
    input  logic                    in_conj,
    output logic                    out_valid,
    output logic [2*LANES*PW-1:0]   out_data
);

    localparam int IN_W  = LANES * PW;
    localparam int OUT_W = 2 * IN_W;

    logic  s1_valid;
    fmt_e  s1_fmt;
    logic  s1_conj;
    fmt_e  s2_fmt;

    wide_t wide_lane [LANES];
    cpx_t  rnd_lane  [LANES];

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            s1_fmt    <= FMT_WIDE;
            s1_conj   <= 1'b0;
            out_valid <= 1'b0;
            s2_fmt    <= FMT_WIDE;
        end else begin
            s1_valid  <= in_valid;
            s1_fmt    <= fmt_e'(in_round);
            s1_conj   <= in_conj;
            out_valid <= s1_valid;
            s2_fmt    <= s1_fmt;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        prod_t prod_l;

        cmul_prod u_prod (
            .clk    (clk),
            .rst    (rst),
            .op_a   (cpx_t'(in_a[l*PW +: PW])),
            .op_b   (cpx_t'(in_b[l*PW +: PW])),
            .prod_q (prod_l)
        );

        cmul_combine u_comb (
            .clk    (clk),
            .rst    (rst),
            .prod   (prod_l),
            .conj   (s1_conj),
            .wide_q (wide_lane[l]),
            .rnd_q  (rnd_lane[l])
        );
    end

    always_comb begin
        out_data = '0;
        for (int l = 0; l < LANES; l++) begin
            if (s2_fmt == FMT_ROUND) out_data[l*PW +: PW]     = rnd_lane[l];
            else                     out_data[l*2*PW +: 2*PW] = wide_lane[l];
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !out_valid); // R6
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_a == '0) |=> ##1 (out_data == '0)); // R2
    AST_ROUND_UPPER: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_round) |=> ##1 (out_data[OUT_W-1:IN_W] == '0)); // R5

endmodule

// File: tb/cpx_simd_mul_test.sv
`timescale 1ns/1ps
module cpx_simd_mul_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [63:0]  in_a = '0;
    logic [63:0]  in_b = '0;
    logic         in_round = 1'b0;
    logic         in_conj = 1'b0;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected pipeline, two issues deep
    logic         p1_v = 1'b0, p2_v = 1'b0;
    logic         p1_r = 1'b0, p2_r = 1'b0;
    logic [127:0] p1_d = '0, p2_d = '0;
    string        p1_t = "", p2_t = "";

    always #10 clk = ~clk;

    cpx_simd_mul uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_round(in_round), .in_conj(in_conj),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic longint rnd15(longint v);
        longint s;
        s = (v + 64'sd16384) >>> 15;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    function automatic logic [127:0] model(logic [63:0] a, logic [63:0] b, bit r, bit c);
        logic [127:0] d;
        d = '0;
        for (int l = 0; l < 2; l++) begin
            longint ar, ai, br, bi, re, im, rr, ri;
            ar = longint'($signed(a[32*l+16 +: 16]));
            ai = longint'($signed(a[32*l    +: 16]));
            br = longint'($signed(b[32*l+16 +: 16]));
            bi = longint'($signed(b[32*l    +: 16]));
            if (c) begin re = ar*br + ai*bi; im = ai*br - ar*bi; end
            else   begin re = ar*br - ai*bi; im = ar*bi + ai*br; end
            if (r) begin
                rr = rnd15(re); ri = rnd15(im);
                d[32*l+16 +: 16] = rr[15:0];
                d[32*l    +: 16] = ri[15:0];
            end else begin
                d[64*l+32 +: 32] = re[31:0];
                d[64*l    +: 32] = im[31:0];
            end
        end
        return d;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: compare output with the issue from two cycles back, then issue
    task automatic step(bit v, logic [63:0] a, logic [63:0] b, bit r, bit c, string tag);
        @(negedge clk);
        check("R6", 128'(out_valid), 128'(p2_v));
        if (p2_v) begin
            if (p2_r) begin
                check(p2_t, 128'(out_data[63:0]), 128'(p2_d[63:0]));
                check("R5", 128'(out_data[127:64]), 128'd0);
            end else begin
                check(p2_t, out_data, p2_d);
            end
        end
        p2_v = p1_v; p2_r = p1_r; p2_d = p1_d; p2_t = p1_t;
        in_valid = v; in_a = a; in_b = b; in_round = r; in_conj = c;
        p1_v = v; p1_r = r; p1_d = model(a, b, r, c);
        if (tag != "")   p1_t = tag;
        else if (r)      p1_t = "R4";
        else if (c)      p1_t = "R3";
        else             p1_t = "R2";
    endtask

    function automatic logic [15:0] pick16();
        case ($urandom_range(0, 4))
            0: return 16'h8000;
            1: return 16'h7FFF;
            2: return 16'h0000;
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic logic [63:0] pick64();
        return {pick16(), pick16(), pick16(), pick16()};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7", 128'(out_valid), 128'd0);
        check("R7", out_data, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R7", out_data, 128'd0);

        // R1: lane isolation and element packing
        step(1, 64'h0000_0000_0003_0002, 64'h1234_5678_0005_0007, 0, 0, "R1");
        step(1, 64'h0003_0002_0000_0000, 64'h0005_0007_9ABC_DEF0, 0, 0, "R1");
        step(1, 64'h0003_0002_0000_0000, 64'h0005_0007_9ABC_DEF0, 1, 0, "R1");
        // R2 / R4 extremes: (-32768)^2 summed twice wraps or saturates
        step(1, 64'h8000_8000_8000_8000, 64'h8000_7FFF_8000_8000, 0, 0, "");
        step(1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 0, 1, "");
        step(1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 1, 1, "");
        step(1, 64'h7FFF_7FFF_8000_7FFF, 64'h7FFF_8000_7FFF_7FFF, 1, 0, "");
        step(1, 64'h7FFF_0000_8000_0000, 64'h7FFF_0000_7FFF_0000, 1, 0, "");
        // R3: conjugate with -32768 imaginary in b
        step(1, 64'h0001_0001_7FFF_8000, 64'h0002_8000_8000_8000, 0, 1, "");
        // R4: rounding boundary, +/- half LSB
        step(1, 64'h4000_0000_C000_0000, 64'h0001_0000_0001_0000, 1, 0, "");
        step(1, 64'h0001_0000_FFFF_0000, 64'h4000_0000_4000_0000, 1, 0, "");
        // R8: alternating selects back to back, with gaps
        for (int i = 0; i < 16; i++)
            step(1, pick64(), pick64(), i[0], i[1], "R8");
        step(0, pick64(), pick64(), 1, 0, "");
        step(1, pick64(), pick64(), 0, 1, "R8");
        step(0, pick64(), pick64(), 0, 0, "");
        step(1, pick64(), pick64(), 1, 1, "R8");
        // random mix
        for (int i = 0; i < 400; i++)
            step($urandom_range(0, 3) != 0, pick64(), pick64(),
                 1'($urandom), 1'($urandom), "");
        repeat (3) step(0, '0, '0, 0, 0, "");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule